// File: doc/BRIEF.md
# Dirty Rectangle Tracker

This block keeps a running bounding box of the framebuffer area that has been written since the last panel refresh. Each finished window write reports its origin and size, and the box is stretched to enclose it. When the refresh logic asks for work, the tracker answers, one cycle later, with exactly one of three pulses: a rectangle to copy (origin plus size), a clear-screen command, or a "nothing to copy" indication. After a copy has been handed out, the box is returned to an inverted empty state.

A pending-invalidate flag forces the next serviced refresh to cover the whole panel. It is raised by an explicit invalidate request, by any change of the panel width or height inputs, and by a display-mode write whose two low bits differ from the stored ones (bit 0 enables the display, bit 1 blanks it). If the panel is blanked when an invalidated refresh is serviced, the tracker issues a clear command instead of a rectangle. While the display is disabled, refresh requests are dropped.

Top module: `dirty_rect_tracker`

## Requirements
- R1: After reset all result pulses are low, the stored mode is 0 (display disabled, not blanked) and the invalidate flag is set, so the first serviced refresh reports the full panel.
- R2: A window write (x, y, w, h) grows the box to lo_x = min(lo_x, x), lo_y = min(lo_y, y), hi_x = max(hi_x, x + w), hi_y = max(hi_y, y + h).
- R3: A serviced refresh with a non-empty box and no pending invalidate raises rect_valid for exactly one cycle, in the cycle after the request, with origin (lo_x, lo_y) and size (hi_x - lo_x, hi_y - lo_y).
- R4: A serviced refresh with hi_x <= lo_x and no pending invalidate raises none_valid for one cycle and emits no rectangle.
- R5: After a rectangle is emitted the box becomes lo_x = panel width, hi_x = 0, lo_y = panel height, hi_y = 0, so a later write alone defines the next rectangle.
- R6: A serviced refresh with the invalidate flag set and blank = 0 emits the rectangle (0, 0, panel width, panel height), clears the flag and empties the box.
- R7: A serviced refresh with the invalidate flag set and blank = 1 raises clear_valid for one cycle, emits no rectangle and clears the flag.
- R8: A mode write sets the invalidate flag only when mode_wdata[1:0] differs from the stored bits; upper mode bits are ignored.
- R9: A change on panel_w or panel_h sets the invalidate flag.
- R10: While the stored enable bit (mode bit 0) is 0, refresh requests produce no pulse and leave box and flag untouched.
- R11: A window write in the same cycle as a serviced refresh is not part of the rectangle emitted for that refresh but is kept for the following one.
- R12: An invalidate source active in the same cycle as a serviced refresh does not affect that refresh, and the flag stays set for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | A window write finished this cycle |
| win_x | input | XW | Window left column |
| win_y | input | YW | Window top row |
| win_w | input | XW | Window width in pixels |
| win_h | input | YW | Window height in lines |
| panel_w | input | XW | Current panel width |
| panel_h | input | YW | Current panel height |
| mode_wr | input | 1 | Display-mode write strobe |
| mode_wdata | input | MODE_W | Display-mode write value (bit 0 enable, bit 1 blank) |
| inval_req | input | 1 | Force the next refresh to cover the panel |
| refresh_req | input | 1 | Refresh asks for the area to copy |
| disp_en | output | 1 | Stored enable bit |
| disp_blank | output | 1 | Stored blank bit |
| rect_valid | output | 1 | One-cycle pulse: rectangle outputs are valid |
| rect_x | output | XW | Rectangle left column |
| rect_y | output | YW | Rectangle top row |
| rect_w | output | XW+1 | Rectangle width |
| rect_h | output | YW+1 | Rectangle height |
| clear_valid | output | 1 | One-cycle pulse: clear the screen |
| none_valid | output | 1 | One-cycle pulse: nothing to copy |

## Verification
Two pairs of functions can meet in one cycle: a window write with a serviced refresh, and an invalidate source (request, mode change or size change) with a serviced refresh. The bench drives both inputs together on the same clock edge; it judges the first pair by checking that the emitted rectangle excludes the new window and that the next refresh reports exactly that window, and the second by checking that the current refresh reports the old box state while the following refresh reports the full panel.

// File: rtl/drt_pkg.sv
package drt_pkg;
   // Outcome of a serviced refresh
   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_RECT  = 2'd1,
      RES_CLEAR = 2'd2,
      RES_FULL  = 2'd3
   } drt_result_e;

   localparam int unsigned MODE_EN_BIT    = 0;
   localparam int unsigned MODE_BLANK_BIT = 1;
endpackage

// File: rtl/drt_extent.sv
// One axis of the dirty box: running minimum and maximum.
module drt_extent #(
   parameter int unsigned W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic [W-1:0] pos,
   input  logic [W-1:0] len,
   input  logic         flush,
   input  logic [W-1:0] span,
   output logic [W:0]   lo,
   output logic [W:0]   hi
);
   localparam int unsigned DW = W + 1;

   if (W < 2) begin : g_bad_width
      $error("drt_extent: W must be at least 2");
   end

   logic [DW-1:0] base_lo, base_hi, end_pos, lo_n, hi_n;

   always_comb begin
      base_lo = flush ? {1'b0, span} : lo;
      base_hi = flush ? '0 : hi;
      end_pos = {1'b0, pos} + {1'b0, len};
      lo_n    = base_lo;
      hi_n    = base_hi;
      if (upd) begin
         if ({1'b0, pos} < base_lo) lo_n = {1'b0, pos};
         if (end_pos > base_hi)     hi_n = end_pos;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo <= '1;
         hi <= '0;
      end else begin
         lo <= lo_n;
         hi <= hi_n;
      end
   end

   AST_GROW_LO: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> lo <= {1'b0, $past(pos)}); // R2
   AST_GROW_HI: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> hi >= ({1'b0, $past(pos)} + {1'b0, $past(len)})); // R2
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !upd) |=> (hi == '0) && (lo == {1'b0, $past(span)})); // R5
endmodule

// File: rtl/drt_inval.sv
// Stored display mode, panel-size watch and pending-invalidate flag.
module drt_inval #(
   parameter int unsigned XW     = 11,
   parameter int unsigned YW     = 10,
   parameter int unsigned MODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic [XW-1:0]     panel_w,
   input  logic [YW-1:0]     panel_h,
   input  logic              inval_req,
   input  logic              consume,
   output logic              inval,
   output logic              en,
   output logic              blank
);
   import drt_pkg::*;

   if (MODE_W < 2) begin : g_bad_mode
      $error("drt_inval: MODE_W must be at least 2");
   end

   logic [1:0]    mode_q;
   logic [XW-1:0] pw_q;
   logic [YW-1:0] ph_q;
   logic          mode_chg, size_chg, set_any;

   assign mode_chg = mode_wr && (mode_wdata[1:0] != mode_q);
   assign size_chg = (panel_w != pw_q) || (panel_h != ph_q);
   assign set_any  = inval_req || mode_chg || size_chg;
   assign en       = mode_q[MODE_EN_BIT];
   assign blank    = mode_q[MODE_BLANK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         pw_q   <= '0;
         ph_q   <= '0;
         inval  <= 1'b1;
      end else begin
         if (mode_wr) mode_q <= mode_wdata[1:0];
         pw_q <= panel_w;
         ph_q <= panel_h;
         if (set_any)      inval <= 1'b1;
         else if (consume) inval <= 1'b0;
      end
   end

   AST_MODE_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && (mode_wdata[1:0] != {blank, en})) |=> inval); // R8
   AST_SIZE_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (panel_w != pw_q) |=> inval); // R9
   AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !set_any) |=> !inval); // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && inval_req) |=> inval); // R12
endmodule

// File: rtl/dirty_rect_tracker.sv
module dirty_rect_tracker #(
   parameter int unsigned XW     = 11,
   parameter int unsigned YW     = 10,
   parameter int unsigned MODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_valid,
   input  logic [XW-1:0]     win_x,
   input  logic [YW-1:0]     win_y,
   input  logic [XW-1:0]     win_w,
   input  logic [YW-1:0]     win_h,
   input  logic [XW-1:0]     panel_w,
   input  logic [YW-1:0]     panel_h,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              inval_req,
   input  logic              refresh_req,
   output logic              disp_en,
   output logic              disp_blank,
   output logic              rect_valid,
   output logic [XW-1:0]     rect_x,
   output logic [YW-1:0]     rect_y,
   output logic [XW:0]       rect_w,
   output logic [YW:0]       rect_h,
   output logic              clear_valid,
   output logic              none_valid
);
   import drt_pkg::*;

   localparam int unsigned XD = XW + 1;
   localparam int unsigned YD = YW + 1;

   logic [XD-1:0] lo_x, hi_x;
   logic [YD-1:0] lo_y, hi_y;
   logic          inval, take, flush;
   drt_result_e   res;

   assign take = refresh_req && disp_en;

   always_comb begin
      res = RES_NONE;
      if (inval)             res = disp_blank ? RES_CLEAR : RES_FULL;
      else if (hi_x > lo_x)  res = RES_RECT;
   end

   assign flush = take && ((res == RES_RECT) || (res == RES_FULL));

   drt_inval #(.XW(XW), .YW(YW), .MODE_W(MODE_W)) u_inval (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .panel_w    (panel_w),
      .panel_h    (panel_h),
      .inval_req  (inval_req),
      .consume    (take),
      .inval      (inval),
      .en         (disp_en),
      .blank      (disp_blank)
   );

   drt_extent #(.W(XW)) u_ext_x (
      .clk (clk), .rst_n (rst_n), .upd (win_valid), .pos (win_x), .len (win_w),
      .flush (flush), .span (panel_w), .lo (lo_x), .hi (hi_x)
   );

   drt_extent #(.W(YW)) u_ext_y (
      .clk (clk), .rst_n (rst_n), .upd (win_valid), .pos (win_y), .len (win_h),
      .flush (flush), .span (panel_h), .lo (lo_y), .hi (hi_y)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rect_valid  <= 1'b0;
         clear_valid <= 1'b0;
         none_valid  <= 1'b0;
         rect_x      <= '0;
         rect_y      <= '0;
         rect_w      <= '0;
         rect_h      <= '0;
      end else begin
         rect_valid  <= 1'b0;
         clear_valid <= 1'b0;
         none_valid  <= 1'b0;
         if (take) begin
            unique case (res)
               RES_FULL: begin
                  rect_valid <= 1'b1;
                  rect_x     <= '0;
                  rect_y     <= '0;
                  rect_w     <= {1'b0, panel_w};
                  rect_h     <= {1'b0, panel_h};
               end
               RES_RECT: begin
                  rect_valid <= 1'b1;
                  rect_x     <= lo_x[XW-1:0];
                  rect_y     <= lo_y[YW-1:0];
                  rect_w     <= hi_x - lo_x;
                  rect_h     <= hi_y - lo_y;
               end
               RES_CLEAR: clear_valid <= 1'b1;
               default:   none_valid  <= 1'b1;
            endcase
         end
      end
   end

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_req && !disp_en) |=> !(rect_valid || clear_valid || none_valid)); // R10
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rect_valid, clear_valid, none_valid})); // R3
   AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (rect_valid && !$past(take)) |-> 1'b0); // R3
   AST_BLANK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (take && inval && disp_blank) |=> clear_valid && !rect_valid); // R7
endmodule

// File: tb/tb_dirty_rect_tracker.sv
`timescale 1ns/1ps
module tb_dirty_rect_tracker;
   localparam int XW = 11;
   localparam int YW = 10;
   localparam int MW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic win_valid = 1'b0;
   logic [XW-1:0] win_x = '0, win_w = '0, panel_w = 11'd320;
   logic [YW-1:0] win_y = '0, win_h = '0, panel_h = 10'd240;
   logic mode_wr = 1'b0;
   logic [MW-1:0] mode_wdata = '0;
   logic inval_req = 1'b0, refresh_req = 1'b0;
   logic disp_en, disp_blank, rect_valid, clear_valid, none_valid;
   logic [XW-1:0] rect_x;
   logic [YW-1:0] rect_y;
   logic [XW:0]   rect_w;
   logic [YW:0]   rect_h;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   dirty_rect_tracker #(.XW(XW), .YW(YW), .MODE_W(MW)) dut (
      .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_x(win_x), .win_y(win_y),
      .win_w(win_w), .win_h(win_h), .panel_w(panel_w), .panel_h(panel_h),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata), .inval_req(inval_req),
      .refresh_req(refresh_req), .disp_en(disp_en), .disp_blank(disp_blank),
      .rect_valid(rect_valid), .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w),
      .rect_h(rect_h), .clear_valid(clear_valid), .none_valid(none_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic refresh_cycle();
      refresh_req = 1'b1;
      @(negedge clk);
      refresh_req = 1'b0;
   endtask

   task automatic write_win(input int x, input int y, input int w, input int h);
      win_x = x[XW-1:0]; win_y = y[YW-1:0]; win_w = w[XW-1:0]; win_h = h[YW-1:0];
      win_valid = 1'b1;
      @(negedge clk);
      win_valid = 1'b0;
   endtask

   task automatic write_mode(input int v);
      mode_wdata = v[MW-1:0];
      mode_wr = 1'b1;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   // checks result of a refresh taken on the edge just passed, then the pulse end
   task automatic expect_rect(input string req, input int x, input int y, input int w, input int h);
      chk({req, " rect_valid"}, rect_valid, 1);
      chk({req, " rect_x"}, rect_x, x);
      chk({req, " rect_y"}, rect_y, y);
      chk({req, " rect_w"}, rect_w, w);
      chk({req, " rect_h"}, rect_h, h);
      chk({req, " clear_valid"}, clear_valid, 0);
      @(negedge clk);
      chk({req, " rect pulse ends"}, rect_valid, 0);
   endtask

   task automatic expect_none(input string req);
      chk({req, " none_valid"}, none_valid, 1);
      chk({req, " rect_valid"}, rect_valid, 0);
      chk({req, " clear_valid"}, clear_valid, 0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 rect_valid", rect_valid, 0);
      chk("R1 clear_valid", clear_valid, 0);
      chk("R1 none_valid", none_valid, 0);
      chk("R1 disp_en", disp_en, 0);
      chk("R1 disp_blank", disp_blank, 0);
   endtask

   task automatic t_disabled();
      write_win(3, 3, 4, 4);
      refresh_cycle();
      chk("R10 rect_valid", rect_valid, 0);
      chk("R10 none_valid", none_valid, 0);
      chk("R10 clear_valid", clear_valid, 0);
      @(negedge clk);
   endtask

   task automatic t_first_full();
      write_mode(1);
      chk("R8 disp_en", disp_en, 1);
      refresh_cycle();
      expect_rect("R1 R6 full after reset", 0, 0, 320, 240);
      refresh_cycle();
      expect_none("R4 R5 empty after flush");
   endtask

   task automatic t_grow();
      write_win(10, 20, 30, 40);
      write_win(5, 50, 10, 15);
      refresh_cycle();
      expect_rect("R2 R3 union", 5, 20, 35, 45);
      write_win(200, 100, 1, 1);
      refresh_cycle();
      expect_rect("R5 fresh box", 200, 100, 1, 1);
      refresh_cycle();
      expect_none("R4 no writes");
   endtask

   task automatic t_inval_req();
      write_win(7, 7, 2, 2);
      inval_req = 1'b1;
      @(negedge clk);
      inval_req = 1'b0;
      refresh_cycle();
      expect_rect("R6 invalidate", 0, 0, 320, 240);
      refresh_cycle();
      expect_none("R6 flag and box cleared");
   endtask

   task automatic t_mode();
      write_mode(8'h05);
      refresh_cycle();
      expect_none("R8 same low bits");
      write_mode(8'h03);
      chk("R8 disp_blank", disp_blank, 1);
      refresh_cycle();
      chk("R7 clear_valid", clear_valid, 1);
      chk("R7 rect_valid", rect_valid, 0);
      chk("R7 none_valid", none_valid, 0);
      @(negedge clk);
      refresh_cycle();
      expect_none("R7 flag consumed");
      write_mode(8'h01);
      refresh_cycle();
      expect_rect("R8 unblank change", 0, 0, 320, 240);
   endtask

   task automatic t_panel();
      panel_w = 11'd640;
      panel_h = 10'd480;
      @(negedge clk);
      refresh_cycle();
      expect_rect("R9 size change", 0, 0, 640, 480);
      refresh_cycle();
      expect_none("R9 flag cleared");
   endtask

   task automatic t_same_cycle_win();
      write_win(1, 1, 2, 2);
      win_x = 11'd100; win_y = 10'd100; win_w = 11'd4; win_h = 10'd4;
      win_valid = 1'b1;
      refresh_cycle();
      win_valid = 1'b0;
      expect_rect("R11 old box only", 1, 1, 2, 2);
      refresh_cycle();
      expect_rect("R11 new window kept", 100, 100, 4, 4);
   endtask

   task automatic t_same_cycle_inval();
      inval_req = 1'b1;
      refresh_cycle();
      inval_req = 1'b0;
      expect_none("R12 refresh sees old flag");
      refresh_cycle();
      expect_rect("R12 flag kept", 0, 0, 640, 480);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_first_full();
      t_grow();
      t_inval_req();
      t_mode();
      t_panel();
      t_same_cycle_win();
      t_same_cycle_inval();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule